// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block drives the control side of an external analog-to-digital converter from a fast system clock. A single start request loads a set of conversion parameters. The block then steps through three timed phases. First the 5-bit channel/control address is presented for a programmable number of system clocks. Next the chip select goes active and a divided converter clock runs for a programmable number of periods. Last the chip select is released and the address is held for a programmable number of converter-clock periods.

The converter clock period is a programmable number of system clocks. Its high time is the lower half of the period. It toggles only while the chip select is active, and rests at its idle level otherwise. The active levels of the chip select and of the converter clock are each selectable. Busy and a one-cycle done pulse report progress. The start request is a plain level-sampled control pin with no handshake. A request is taken only in a cycle where busy is low, and it is dropped in every other cycle.

Top module: `adc_ctl_seq`

## Requirements
- R1: After reset, busy and done are 0, adc_addr is 0, adc_cs is 1 and adc_clk is 0. Reset sets both polarity settings to 0.
- R2: When start is high at a clock edge while busy is low, all cfg_* inputs are captured. From the next cycle, busy is 1 and adc_addr equals the captured address.
- R3: adc_cs becomes active exactly SC+1 system cycles after adc_addr takes the new address, where SC = cfg_setup (0 to 4095).
- R4: adc_cs stays active for exactly L·P system cycles. Here L = cfg_len+1 (1 to 32) and P = D+1, where D = cfg_div (1 to 255) and a cfg_div of 0 is treated as 1.
- R5: While adc_cs is active, the converter clock repeats with period P. The first cycle of each period starts at the chip-select activation. In each period the clock sits at its active level for the first floor(P/2) cycles and at its idle level for the rest.
- R6: Whenever adc_cs is inactive, adc_clk sits at its idle level.
- R7: With cfg_cs_pol=1 the chip select is active-high; with 0 it is active-low. With cfg_clk_pol=0 the clock idles at 0 and its active level is 1; with cfg_clk_pol=1 both are inverted.
- R8: After adc_cs is released, busy stays 1 for HC·P system cycles (HC = cfg_hold, 0 to 15), with adc_addr unchanged.
- R9: done is high for exactly one cycle: the first cycle in which busy is 0 after a sequence. A start in that cycle is accepted.
- R10: While busy is 1, start and all cfg_* inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sequence request, taken only when idle |
| cfg_addr | input | 5 | Channel/control address to present |
| cfg_div | input | 8 | Clock divider D; period is D+1 system clocks |
| cfg_setup | input | 12 | Address setup count SC |
| cfg_hold | input | 4 | Address hold count HC in converter periods |
| cfg_len | input | 5 | Conversion length minus one, in converter periods |
| cfg_cs_pol | input | 1 | 1: chip select active-high |
| cfg_clk_pol | input | 1 | 1: inverted converter clock |
| adc_clk | output | 1 | Divided converter clock |
| adc_cs | output | 1 | Converter chip select |
| adc_addr | output | 5 | Channel/control address bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Taking the accepting edge as cycle 0, every output follows a fixed schedule measured in whole system cycles. Busy and the address change in cycle 1. The chip select goes active in cycle SC+2 and is released in cycle SC+2+L·P. Done appears in cycle SC+2+(L+HC)·P. The clock level in an active cycle depends only on the offset from activation modulo P. The bench keeps an integer offset from the accepting edge and derives every expected output from these formulas. It compares all five outputs at the falling edge of every cycle, after the registers settled at the preceding rising edge. Runs cover odd and even periods, zero setup and hold, the clamped divider, both polarities, and requests made while busy and in the done cycle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adcseq_timebase.sv
// Phase counter inside one converter-clock period.
module adcseq_timebase #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] ph,
  output logic             wrap
);
  assign wrap = run && (ph == div);

  always_ff @(posedge clk) begin
    if (!rst_n)       ph <= '0;
    else if (!run)    ph <= '0;
    else if (wrap)    ph <= '0;
    else              ph <= ph + 1'b1;
  end

  // The phase never passes the last slot of a period
  assert_phase_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph <= div);
endmodule

// File: rtl/adcseq_ctrl.sv
// Phase sequencer with the configuration captured at acceptance.
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 8,
  parameter int SETUP_W = 12,
  parameter int HOLD_W  = 4,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_cs_pol,
  input  logic               cfg_clk_pol,
  input  logic               wrap,
  output seq_state_e         state,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [DIV_W-1:0]   div_q,
  output logic               cs_pol_q,
  output logic               clk_pol_q,
  output logic               done
);
  localparam int CNT_W = (LEN_W > HOLD_W) ? LEN_W : HOLD_W;

  logic [SETUP_W-1:0] sc_cnt;
  logic [CNT_W-1:0]   per_cnt;
  logic [LEN_W-1:0]   len_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [CNT_W-1:0]   len_ext, hold_ext;
  logic               accept;

  assign len_ext  = CNT_W'(len_q);
  assign hold_ext = CNT_W'(hold_q);
  assign accept   = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      div_q     <= DIV_W'(1);
      cs_pol_q  <= 1'b0;
      clk_pol_q <= 1'b0;
      len_q     <= '0;
      hold_q    <= '0;
      sc_cnt    <= '0;
      per_cnt   <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          addr_q    <= cfg_addr;
          div_q     <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
          cs_pol_q  <= cfg_cs_pol;
          clk_pol_q <= cfg_clk_pol;
          len_q     <= cfg_len;
          hold_q    <= cfg_hold;
          sc_cnt    <= cfg_setup;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (sc_cnt == '0) begin
            state   <= ST_ACTIVE;
            per_cnt <= '0;
          end else begin
            sc_cnt <= sc_cnt - 1'b1;
          end
        end
        ST_ACTIVE: if (wrap) begin
          if (per_cnt == len_ext) begin
            per_cnt <= '0;
            if (hold_q == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_HOLD;
            end
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end
        ST_HOLD: if (wrap) begin
          if (per_cnt == hold_ext - 1'b1) begin
            per_cnt <= '0;
            state   <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            per_cnt <= per_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Activation only follows an exhausted setup count
  assert_setup_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_ACTIVE) |-> $past(state == ST_SETUP && sc_cnt == '0));

  // Captured configuration is frozen for the whole sequence
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(addr_q) && $stable(div_q) &&
                            $stable(cs_pol_q) && $stable(clk_pol_q)));
endmodule

// File: rtl/adcseq_pins.sv
// Converts sequencer state into pin levels with the chosen polarities.
module adcseq_pins
  import adcseq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  seq_state_e       state,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] ph,
  input  logic             cs_pol_q,
  input  logic             clk_pol_q,
  output logic             adc_clk,
  output logic             adc_cs
);
  logic [DIV_W:0] period, hi_len;
  logic           active, clk_raw;

  assign period  = {1'b0, div_q} + 1'b1;
  assign hi_len  = period >> 1;
  assign active  = (state == ST_ACTIVE);
  assign clk_raw = active && ({1'b0, ph} < hi_len);
  assign adc_clk = clk_raw ^ clk_pol_q;
  assign adc_cs  = active ? cs_pol_q : ~cs_pol_q;
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adcseq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 8,
  parameter int SETUP_W = 12,
  parameter int HOLD_W  = 4,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_cs_pol,
  input  logic               cfg_clk_pol,
  output logic               adc_clk,
  output logic               adc_cs,
  output logic [ADDR_W-1:0]  adc_addr,
  output logic               busy,
  output logic               done
);
  seq_state_e       state;
  logic [DIV_W-1:0] div_q, ph;
  logic             cs_pol_q, clk_pol_q, wrap, run;

  assign run  = (state == ST_ACTIVE) || (state == ST_HOLD);
  assign busy = (state != ST_IDLE);

  adcseq_ctrl #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .SETUP_W(SETUP_W),
    .HOLD_W(HOLD_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_addr(cfg_addr), .cfg_div(cfg_div), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_len(cfg_len),
    .cfg_cs_pol(cfg_cs_pol), .cfg_clk_pol(cfg_clk_pol),
    .wrap(wrap), .state(state), .addr_q(adc_addr), .div_q(div_q),
    .cs_pol_q(cs_pol_q), .clk_pol_q(clk_pol_q), .done(done)
  );

  adcseq_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .ph(ph), .wrap(wrap)
  );

  adcseq_pins #(.DIV_W(DIV_W)) u_pins (
    .state(state), .div_q(div_q), .ph(ph),
    .cs_pol_q(cs_pol_q), .clk_pol_q(clk_pol_q),
    .adc_clk(adc_clk), .adc_cs(adc_cs)
  );

  // done only ends a sequence that was running
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Address bus does not move while a sequence runs
  assert_addr_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(adc_addr));
endmodule

// File: tb/test_adc_ctl_seq.sv
module test_adc_ctl_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_div = '0;
  logic [11:0] cfg_setup = '0;
  logic [3:0]  cfg_hold = '0;
  logic [4:0]  cfg_len = '0;
  logic        cfg_cs_pol = 1'b0, cfg_clk_pol = 1'b0;
  logic        adc_clk, adc_cs, busy, done;
  logic [4:0]  adc_addr;

  always #10 clk = ~clk;  // 50 MHz

  adc_ctl_seq i_adc_ctl_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr(cfg_addr),
    .cfg_div(cfg_div), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
    .cfg_len(cfg_len), .cfg_cs_pol(cfg_cs_pol), .cfg_clk_pol(cfg_clk_pol),
    .adc_clk(adc_clk), .adc_cs(adc_cs), .adc_addr(adc_addr),
    .busy(busy), .done(done)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: offset k from the accepting edge, -1 when idle
  int k = -1, total = 0, m_sc = 0, m_p = 2, m_h = 1, m_l = 1, m_hc = 0;
  logic [4:0] m_addr = '0;
  bit m_csp = 0, m_clkp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      k = -1; m_addr = '0; m_csp = 0; m_clkp = 0;
    end else if ((k < 0 || k == total) && start) begin
      m_addr = cfg_addr;
      m_p    = ((cfg_div == 0) ? 1 : int'(cfg_div)) + 1;
      m_h    = m_p / 2;
      m_sc   = int'(cfg_setup);
      m_l    = int'(cfg_len) + 1;
      m_hc   = int'(cfg_hold);
      m_csp  = cfg_csp_sample();
      m_clkp = cfg_clk_pol;
      total  = (m_sc + 1) + (m_l + m_hc) * m_p;
      k = 0;
    end else if (k >= 0 && k < total) k++;
    else k = -1;
  end

  function automatic bit cfg_csp_sample();
    return cfg_cs_pol;
  endfunction

  // Compare every output at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit in_run, in_act, e_busy, e_done, e_clk;
      string cs_tag, clk_tag;
      in_run = (k >= 0 && k < total);
      in_act = in_run && (k >= m_sc + 1) && (k < m_sc + 1 + m_l * m_p);
      e_busy = in_run;
      e_done = (k == total);
      // R7: polarity applied to both pins
      e_clk  = (in_act && (((k - m_sc - 1) % m_p) < m_h)) ^ m_clkp;
      if (!in_run)       cs_tag = "R9";
      else if (k <= m_sc) cs_tag = "R3";
      else if (in_act)   cs_tag = "R4";
      else               cs_tag = "R8";
      clk_tag = in_act ? "R5" : "R6";
      chk("R2", "busy", int'(busy), int'(e_busy));
      chk("R9", "done", int'(done), int'(e_done));
      chk(cs_tag, "adc_cs", int'(adc_cs), int'(in_act ? m_csp : !m_csp));
      chk(clk_tag, "adc_clk", int'(adc_clk), int'(e_clk));
      chk("R10", "adc_addr", int'(adc_addr), int'(m_addr));
    end
  end

  task automatic set_cfg(int a, int d, int s, int h, int l, bit cp, bit kp);
    cfg_addr = 5'(a); cfg_div = 8'(d); cfg_setup = 12'(s);
    cfg_hold = 4'(h); cfg_len = 5'(l); cfg_cs_pol = cp; cfg_clk_pol = kp;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_txn(int a, int d, int s, int h, int l, bit cp, bit kp);
    @(posedge clk); #2;
    set_cfg(a, d, s, h, l, cp, kp);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "adc_cs", int'(adc_cs), 1);
    chk("R1", "adc_clk", int'(adc_clk), 0);
    chk("R1", "adc_addr", int'(adc_addr), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) @(posedge clk);

    run_txn(5'h11, 3, 2, 1, 1, 0, 0);   // even period
    run_txn(5'h0A, 0, 0, 0, 0, 1, 1);   // clamped divider, no setup, no hold
    // R10: odd period, requests and new settings while busy
    @(posedge clk); #2;
    set_cfg(5'h1F, 4, 5, 3, 3, 1, 0);
    start = 1'b1;
    @(posedge clk); #2;
    set_cfg(5'h02, 1, 0, 0, 0, 0, 1);
    repeat (12) @(posedge clk);
    #2 start = 1'b0;
    wait_done();
    // R9: start held through done, second sequence taken in the done cycle
    @(posedge clk); #2;
    set_cfg(5'h07, 2, 1, 2, 2, 0, 1);
    start = 1'b1;
    wait_done();
    @(posedge clk); #2;
    set_cfg(5'h15, 5, 3, 1, 1, 1, 0);
    @(posedge clk); #2;
    start = 1'b0;
    wait_done();
    run_txn(5'h03, 255, 40, 15, 31, 0, 0);  // maximal divider, hold, length
    repeat (5) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule